// File: doc/BRIEF.md
# Serial EEPROM Word Address Pointer

This block keeps the internal byte address of a serial EEPROM whose capacity is set at build time to 1, 2, 4, 8 or 16 kbit. A bus front end feeds it two load strobes. One carries the high address bits that ride in the device select byte. The other carries the 8-bit word address byte. The front end also pulses an increment strobe after every byte transferred, and a mode flag tells the pointer whether the transfer was a write or a read.

During writes the pointer advances only inside the current page, so a long burst wraps to the start of that page and overwrites earlier bytes. During reads it advances across the whole array, and after the top address it returns to zero. Between transactions the pointer keeps its value, so a later read with no address phase continues from one past the last byte touched.

Top module: `eeAddrPtr`

## Requirements
- R1: After reset `memAddr` is 0. The output width is 11 bits for 16 kbit, 10 for 8 kbit, 9 for 4 kbit, 8 for 2 kbit and 7 for 1 kbit.
- R2: A `wordLoad` pulse writes `wordAddr` into the low address bits and leaves the high bits unchanged. For 1 kbit only `wordAddr[6:0]` is used and bit 7 is ignored.
- R3: A `devLoad` pulse writes the bits above bit 7, taking them from `devBits` from the top down. For 16 kbit `devBits[2:0]` drives `memAddr[10:8]`. For 8 kbit `devBits[2:1]` drives `memAddr[9:8]`. For 4 kbit `devBits[2]` drives `memAddr[8]`. The remaining `devBits` are ignored. For 1 and 2 kbit the pulse changes nothing.
- R4: An `incStrobe` with `writeMode`=1 adds one to the in-page offset only, modulo the page size (16 bytes for 4 kbit and larger, 8 bytes for 1 and 2 kbit). The page bits stay as they are.
- R5: An `incStrobe` with `writeMode`=0 adds one to the whole address, modulo the array size, so the last address is followed by 0.
- R6: When `devLoad` or `wordLoad` is high in the same cycle as `incStrobe`, the load takes effect and no increment happens.
- R7: With no strobe the address holds. A read that follows a write burst continues from the value the burst left behind.
- R8: If `devLoad` and `wordLoad` arrive in the same cycle, both fields are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| devLoad | input | 1 | Load high address bits from `devBits` |
| devBits | input | 3 | Device select byte bits 3..1 |
| wordLoad | input | 1 | Load low address bits from `wordAddr` |
| wordAddr | input | 8 | Word address byte |
| incStrobe | input | 1 | Advance after a byte |
| writeMode | input | 1 | 1 = write wrap (page), 0 = read wrap (array) |
| memAddr | output | ADDR_W | Current memory address |

## Verification
An address load and a byte increment can land in the same cycle, for example when a new address phase starts right after the last data byte. The bench raises `incStrobe` together with `wordLoad` alone, with `devLoad` alone, and with both loads. In each case it checks that the result equals the freshly loaded value and not that value plus one. Two instances run side by side, one at 16 kbit and one at 1 kbit, so both the 16-byte and 8-byte page wraps are judged against an arithmetic model in the bench.

// File: rtl/eeAddrPkg.sv
package eeAddrPkg;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic stepPage;
    logic stepFull;
  } ptrCmd_t;

  function automatic int addrWidth(input int kbits);
    case (kbits)
      1:       return 7;
      2:       return 8;
      4:       return 9;
      8:       return 10;
      default: return 11;
    endcase
  endfunction

  function automatic int pageBits(input int kbits);
    return (kbits <= 2) ? 3 : 4;
  endfunction

endpackage

// File: rtl/eeAddrCtrl.sv
module eeAddrCtrl
  import eeAddrPkg::*;
#(
  parameter int HI_W = 3
) (
  input  logic    devLoad,
  input  logic    wordLoad,
  input  logic    incStrobe,
  input  logic    writeMode,
  output ptrCmd_t cmd
);

  logic anyLoad;

  always_comb begin
    anyLoad      = devLoad | wordLoad;
    cmd.loadHi   = devLoad && (HI_W > 0);
    cmd.loadLo   = wordLoad;
    // a load always overrides a byte step
    cmd.stepPage = incStrobe &  writeMode & ~anyLoad;
    cmd.stepFull = incStrobe & ~writeMode & ~anyLoad;
  end

endmodule

// File: rtl/eeAddrPath.sv
module eeAddrPath
  import eeAddrPkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_BITS = 4,
  parameter int LO_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptrCmd_t           cmd,
  input  logic [2:0]        devBits,
  input  logic [7:0]        wordAddr,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] hiMerged;
  logic [ADDR_W-1:0] loadVal;
  logic [ADDR_W-1:0] pageNext;
  logic [ADDR_W-1:0] addrNext;

  generate
    if (HI_W > 0) begin : g_hi
      assign hiMerged = {devBits[2 -: HI_W], addrQ[LO_W-1:0]};
    end else begin : g_nohi
      assign hiMerged = addrQ;
    end
  endgenerate

  always_comb begin
    loadVal = cmd.loadHi ? hiMerged : addrQ;
    if (cmd.loadLo) loadVal[LO_W-1:0] = wordAddr[LO_W-1:0];
    pageNext = {addrQ[ADDR_W-1:PAGE_BITS], addrQ[PAGE_BITS-1:0] + 1'b1};
    if (cmd.loadHi || cmd.loadLo) addrNext = loadVal;
    else if (cmd.stepPage)        addrNext = pageNext;
    else if (cmd.stepFull)        addrNext = addrQ + 1'b1;
    else                          addrNext = addrQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addrQ <= '0;
    else        addrQ <= addrNext;
  end

  assign memAddr = addrQ;

endmodule

// File: rtl/eeAddrPtr.sv
module eeAddrPtr
  import eeAddrPkg::*;
#(
  parameter  int MEM_KBITS = 16,
  localparam int ADDR_W    = addrWidth(MEM_KBITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              devLoad,
  input  logic [2:0]        devBits,
  input  logic              wordLoad,
  input  logic [7:0]        wordAddr,
  input  logic              incStrobe,
  input  logic              writeMode,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int PAGE_BITS = pageBits(MEM_KBITS);
  localparam int LO_W      = (ADDR_W < 8) ? ADDR_W : 8;
  localparam int HI_W      = ADDR_W - LO_W;

  ptrCmd_t cmd;

  eeAddrCtrl #(.HI_W(HI_W)) i_ctrl (
    .devLoad  (devLoad),
    .wordLoad (wordLoad),
    .incStrobe(incStrobe),
    .writeMode(writeMode),
    .cmd      (cmd)
  );

  eeAddrPath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LO_W(LO_W)) i_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .devBits (devBits),
    .wordAddr(wordAddr),
    .memAddr (memAddr)
  );

endmodule

// File: rtl/eeAddrPtrChk.sv
module eeAddrPtrChk
  import eeAddrPkg::*;
#(
  parameter  int MEM_KBITS = 16,
  localparam int ADDR_W    = addrWidth(MEM_KBITS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              devLoad,
  input logic [2:0]        devBits,
  input logic              wordLoad,
  input logic [7:0]        wordAddr,
  input logic              incStrobe,
  input logic              writeMode,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int PB   = pageBits(MEM_KBITS);
  localparam int LO_W = (ADDR_W < 8) ? ADDR_W : 8;
  localparam int HI_W = ADDR_W - LO_W;

  logic anyLoad;
  assign anyLoad = devLoad | wordLoad;

  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wordLoad |=> memAddr[LO_W-1:0] == $past(wordAddr[LO_W-1:0]));

  // R4
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incStrobe && writeMode && !anyLoad) |=>
      (memAddr[ADDR_W-1:PB] == $past(memAddr[ADDR_W-1:PB])) &&
      (memAddr[PB-1:0] == PB'($past(memAddr[PB-1:0]) + 1'b1)));

  // R5
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incStrobe && !writeMode && !anyLoad) |=>
      memAddr == ADDR_W'($past(memAddr) + 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!incStrobe && !anyLoad) |=> $stable(memAddr));

  generate
    if (HI_W > 0) begin : g_hiChk
      // R3
      dev_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        devLoad |=> memAddr[ADDR_W-1:LO_W] == $past(devBits[2 -: HI_W]));
      // R2
      word_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wordLoad && !devLoad) |=> $stable(memAddr[ADDR_W-1:LO_W]));
    end
  endgenerate

endmodule

bind eeAddrPtr eeAddrPtrChk #(.MEM_KBITS(MEM_KBITS)) i_eeAddrPtrChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .devLoad  (devLoad),
  .devBits  (devBits),
  .wordLoad (wordLoad),
  .wordAddr (wordAddr),
  .incStrobe(incStrobe),
  .writeMode(writeMode),
  .memAddr  (memAddr)
);

// File: tb/test_eeAddrPtr.sv
module test_eeAddrPtr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       devLoad = 1'b0;
  logic [2:0] devBits = '0;
  logic       wordLoad = 1'b0;
  logic [7:0] wordAddr = '0;
  logic       incStrobe = 1'b0;
  logic       writeMode = 1'b0;
  logic [10:0] memBig;
  logic [6:0]  memSmall;

  int tests = 0;
  int fails = 0;
  int modelBig = 0;
  int modelSmall = 0;
  bit done = 1'b0;

  typedef struct {
    int    expBig;
    int    expSmall;
    string tag;
  } expItem_t;
  expItem_t sb[$];

  always #5 clk = ~clk;

  eeAddrPtr #(.MEM_KBITS(16)) i_eeAddrPtr (
    .clk(clk), .rst_n(rst_n), .devLoad(devLoad), .devBits(devBits),
    .wordLoad(wordLoad), .wordAddr(wordAddr), .incStrobe(incStrobe),
    .writeMode(writeMode), .memAddr(memBig)
  );

  eeAddrPtr #(.MEM_KBITS(1)) i_eeAddrPtrSmall (
    .clk(clk), .rst_n(rst_n), .devLoad(devLoad), .devBits(devBits),
    .wordLoad(wordLoad), .wordAddr(wordAddr), .incStrobe(incStrobe),
    .writeMode(writeMode), .memAddr(memSmall)
  );

  function automatic int stepModel(int kb, int cur, bit dl, int db, bit wl,
                                   int wa, bit inc, bit wr);
    int aw, pg, hb, lo, n;
    aw = (kb == 16) ? 11 : (kb == 8) ? 10 : (kb == 4) ? 9 : (kb == 2) ? 8 : 7;
    pg = (kb >= 4) ? 16 : 8;
    hb = (aw > 8) ? aw - 8 : 0;
    lo = (aw < 8) ? 128 : 256;
    n  = cur;
    if (dl || wl) begin
      if (dl && hb > 0) n = (n % 256) + ((db >> (3 - hb)) * 256);
      if (wl) n = n - (n % lo) + (wa % lo);
    end else if (inc) begin
      if (wr) n = n - (n % pg) + ((n % pg) + 1) % pg;
      else    n = (n + 1) % (1 << aw);
    end
    return n;
  endfunction

  task automatic drive(bit dl, int db, bit wl, int wa, bit inc, bit wr, string tag);
    expItem_t it;
    @(negedge clk);
    devLoad = dl; devBits = 3'(db); wordLoad = wl; wordAddr = 8'(wa);
    incStrobe = inc; writeMode = wr;
    modelBig   = stepModel(16, modelBig,   dl, db, wl, wa, inc, wr);
    modelSmall = stepModel(1,  modelSmall, dl, db, wl, wa, inc, wr);
    it.expBig = modelBig; it.expSmall = modelSmall; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares one item per clock, shortly after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      tests++;
      if (int'(memBig) != it.expBig || int'(memSmall) != it.expSmall) begin
        fails++;
        $display("FAIL %s: big=%0h small=%0h expected big=%0h small=%0h",
                 it.tag, memBig, memSmall, it.expBig, it.expSmall);
      end
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tests++;
    if (memBig != 0 || memSmall != 0) begin
      fails++;
      $display("FAIL R1: big=%0h small=%0h expected 0 0", memBig, memSmall);
    end
    drive(0, 0, 0, 0, 0, 0, "R7 idle hold");
    drive(0, 0, 1, 'h5A, 0, 0, "R2 word load");
    drive(1, 5, 0, 0, 0, 0, "R3 device bits");
    drive(0, 0, 1, 'hFF, 0, 1, "R2 word load bit7");
    for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 1, 1, "R4 page wrap");
    drive(0, 0, 0, 0, 0, 0, "R7 hold after write");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 0, "R7 read continues");
    drive(1, 7, 1, 'hFE, 0, 0, "R8 both loads");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 0, "R5 array wrap");
    drive(0, 0, 1, 'h10, 1, 0, "R6 word load beats inc");
    drive(1, 2, 0, 0, 1, 1, "R6 device load beats inc");
    drive(1, 6, 1, 'h33, 1, 1, "R6 both loads beat inc");
    drive(1, 3, 0, 0, 0, 0, "R3 other device value");
    for (int i = 0; i < 9; i++) drive(0, 0, 0, 0, 1, 1, "R4 second page");
    drive(0, 0, 0, 0, 0, 0, "R7 final hold");
    @(negedge clk);
    devLoad = 0; wordLoad = 0; incStrobe = 0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    finishRun();
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      finishRun();
    end
  end

endmodule